// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Store Queue

This block sits between a processor's load/store port and a slower word-wide memory. Lookups go to a direct-mapped array: one tag comparator, one line per index, one data word per line. Every store is placed in a first-in first-out queue of address/data pairs that empties towards memory. A store that finds its line present also updates that line, so the cached copy and memory end up with the same value. A store that misses does not allocate a line. The processor keeps running after a store unless the queue is already full.

Memory has one port with a request/acknowledge handshake. A controller decides between draining the queue and refilling a line after a load miss. The queue always wins. A refill read is issued only when every earlier store has reached memory, so the refill returns the most recent value of that word.

The controller has three states. MC_IDLE goes to MC_WRITE when the queue holds an entry. It goes to MC_READ when the queue is empty and the current load misses. MC_WRITE holds a write request for the queue head and returns to MC_IDLE on acknowledge, popping the entry. MC_READ holds a read request for the stalled load address. On acknowledge it writes the returned word, tag and valid bit into the line, then returns to MC_IDLE.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid and the queue is empty. With the processor idle, mem_req and cpu_stall are low, and the first load of any address misses and stalls.
- R2: A load whose line is valid with a matching tag completes in its first cycle, with cpu_stall low and cpu_rdata holding the cached word. Index = cpu_addr[IDX_W-1:0]; tag = the remaining upper bits.
- R3: A load miss holds cpu_stall high until a memory read for that address is acknowledged. The line is then filled, the load returns the memory word, and a repeat load of that address hits without a memory request.
- R4: A store to a present line updates the cached word at once, so a following load returns the new value without stalling. The store is also written to memory.
- R5: A store that misses does not allocate a line. It reaches memory through the queue, and a later load of that address still misses.
- R6: A store is accepted without stalling while the queue holds fewer than WB_DEPTH entries. It stalls while the queue is full.
- R7: Queued stores are written to memory in arrival order. Each request (mem_we=1) is held with stable address and data until mem_ack.
- R8: A refill read (mem_req with mem_we=0) is issued only when the queue is empty, so a load that misses on a just-stored address returns the stored value.
- R9: Two addresses with the same index and different tags evict each other, so alternating loads to them both miss.
- R10: While the queue is draining to memory, loads that hit complete without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held while cpu_stall is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when cpu_stall is low |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write from queue, 0 = refill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge, ends the request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |

## Verification
Two of this block's functions can fall in the same cycle: the queue accepting a new store while it releases its head to memory, and a processor load hitting while a queued write occupies the memory port. The first is provoked by a burst of five back-to-back stores against a memory with a multi-cycle acknowledge. It is judged by the stall pattern, where only the fifth store stalls, and by the order and values of the writes that memory receives. The second is provoked by a load to a cached word right after three missing stores. It is judged by sampling a write request on the memory port in the same cycle as the load completes unstalled with the correct word.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
    typedef enum logic [1:0] {
        MC_IDLE  = 2'd0,
        MC_WRITE = 2'd1,
        MC_READ  = 2'd2
    } mc_state_t;
endpackage

// File: rtl/wtc_lines.sv
`timescale 1ns/1ps
// Direct-mapped tag/valid/data store with combinational lookup.
module wtc_lines #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    assign idx = lk_addr[IDX_W-1:0];
    assign tag = lk_addr[ADDR_W-1:IDX_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= tag;
            dat_q[idx] <= fill_data;
        end else if (upd_en) begin
            dat_q[idx] <= upd_data;
        end
    end

    assign hit     = vld_q[idx] && (tag_q[idx] == tag);
    assign rd_data = dat_q[idx];

    AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !hit); // R3
endmodule

// File: rtl/wtc_wbuf.sv
`timescale 1ns/1ps
// Store queue: FIFO of address/data pairs. DEPTH must be a power of two >= 2.
module wtc_wbuf #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [ADDR_W-1:0] a_mem [DEPTH];
    logic [DATA_W-1:0] d_mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            a_mem[wr_ptr] <= push_addr;
            d_mem[wr_ptr] <= push_data;
        end
    end

    assign head_addr = a_mem[rd_ptr];
    assign head_data = d_mem[rd_ptr];
    assign empty     = (cnt == '0);
    assign full      = (cnt == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7
endmodule

// File: rtl/wtc_mem_ctrl.sv
`timescale 1ns/1ps
// Memory port arbiter: drains the store queue first, then serves refills.
module wtc_mem_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_empty,
    input  logic [ADDR_W-1:0] wb_head_addr,
    input  logic [DATA_W-1:0] wb_head_data,
    input  logic              load_miss,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wb_pop,
    output logic              fill_en
);
    mc_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MC_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MC_IDLE: begin
                if (!wb_empty)      state_nx = MC_WRITE;
                else if (load_miss) state_nx = MC_READ;
            end
            MC_WRITE: if (mem_ack) state_nx = MC_IDLE;
            MC_READ:  if (mem_ack) state_nx = MC_IDLE;
            default:  state_nx = MC_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        wb_pop    = 1'b0;
        fill_en   = 1'b0;
        unique case (state)
            MC_IDLE: ;
            MC_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wb_head_addr;
                mem_wdata = wb_head_data;
                wb_pop    = mem_ack;
            end
            MC_READ: begin
                mem_req  = 1'b1;
                mem_addr = miss_addr;
                fill_en  = mem_ack;
            end
            default: ;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7
    AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> wb_empty); // R8
endmodule

// File: rtl/wtc_cache.sv
`timescale 1ns/1ps
module wtc_cache #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              hit, load_miss, store_go, upd_en;
    logic              wb_empty, wb_full, wb_pop, fill_en;
    logic [ADDR_W-1:0] wb_head_addr;
    logic [DATA_W-1:0] wb_head_data;

    assign load_miss = cpu_req && !cpu_we && !hit;
    assign store_go  = cpu_req && cpu_we && !wb_full;
    assign upd_en    = store_go && hit;
    assign cpu_stall = load_miss || (cpu_req && cpu_we && wb_full);

    wtc_lines #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (cpu_addr),
        .upd_en    (upd_en),
        .upd_data  (cpu_wdata),
        .fill_en   (fill_en),
        .fill_data (mem_rdata),
        .hit       (hit),
        .rd_data   (cpu_rdata)
    );

    wtc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (store_go),
        .push_addr (cpu_addr),
        .push_data (cpu_wdata),
        .pop       (wb_pop),
        .head_addr (wb_head_addr),
        .head_data (wb_head_data),
        .empty     (wb_empty),
        .full      (wb_full)
    );

    wtc_mem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wb_empty     (wb_empty),
        .wb_head_addr (wb_head_addr),
        .wb_head_data (wb_head_data),
        .load_miss    (load_miss),
        .miss_addr    (cpu_addr),
        .mem_ack      (mem_ack),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .wb_pop       (wb_pop),
        .fill_en      (fill_en)
    );

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en ##1 (cpu_req && !cpu_we && $stable(cpu_addr)) |-> hit); // R3
endmodule

// File: tb/test_wtc_cache.sv
`timescale 1ns/1ps
module test_wtc_cache;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_stall;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wtc_cache i_wtc_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: fixed latency, one-cycle acknowledge, write log.
    logic [DW-1:0] mem [256];
    logic [AW-1:0] log_addr [64];
    int            log_n = 0;
    int            lat_cnt = 0;

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return 32'hC0DE_0000 | {16'h0, a};
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(AW'(i));
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt == LAT) begin
                lat_cnt = 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    if (log_n < 64) log_addr[log_n] = mem_addr;
                    log_n++;
                end else begin
                    mem_rdata <= mem[mem_addr[7:0]];
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_load(input logic [AW-1:0] a, output logic [DW-1:0] d, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        stalls = 0;
        while (cpu_stall) begin
            @(negedge clk); #1;
            stalls++;
        end
        d = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] v, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
        #1;
        stalls = 0;
        while (cpu_stall) begin
            @(negedge clk); #1;
            stalls++;
        end
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d; int s;
        #1;
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);
        chk(cpu_stall == 1'b0, "R1", "cpu_stall idle after reset", 32'(cpu_stall), 0);
        do_load(16'h0003, d, s);
        chk(s > 0, "R1", "first load stalls (line invalid)", 32'(s), 1);
        chk(d == init_val(16'h0003), "R3", "refill data", d, init_val(16'h0003));
        do_load(16'h0003, d, s);
        chk(s == 0, "R3", "reload after refill hits", 32'(s), 0);
    endtask

    task automatic t_hit();
        logic [DW-1:0] d; int s;
        do_load(16'h0021, d, s);
        chk(s > 0, "R3", "miss stalls", 32'(s), 1);
        do_load(16'h0021, d, s);
        chk(s == 0, "R2", "hit no stall", 32'(s), 0);
        chk(d == init_val(16'h0021), "R2", "hit data", d, init_val(16'h0021));
        do_load(16'h0003, d, s);
        chk(s == 0 && d == init_val(16'h0003), "R2", "other line still hits", d, init_val(16'h0003));
    endtask

    task automatic t_store_hit();
        logic [DW-1:0] d; int s;
        do_load(16'h0042, d, s);
        do_store(16'h0042, 32'h1111_2222, s);
        chk(s == 0, "R4", "store hit no stall", 32'(s), 0);
        do_load(16'h0042, d, s);
        chk(s == 0, "R4", "load after store hit no stall", 32'(s), 0);
        chk(d == 32'h1111_2222, "R4", "cached word updated", d, 32'h1111_2222);
        idle(30);
        chk(mem[8'h42] == 32'h1111_2222, "R4", "memory written", mem[8'h42], 32'h1111_2222);
    endtask

    task automatic t_store_miss();
        logic [DW-1:0] d; int s;
        do_store(16'h0057, 32'h0000_5757, s);
        idle(30);
        chk(mem[8'h57] == 32'h0000_5757, "R5", "miss store reaches memory", mem[8'h57], 32'h0000_5757);
        do_load(16'h0057, d, s);
        chk(s > 0, "R5", "no allocate: later load misses", 32'(s), 1);
        chk(d == 32'h0000_5757, "R5", "load returns stored value", d, 32'h0000_5757);
    endtask

    task automatic t_queue();
        int s [5];
        int start;
        start = log_n;
        for (int i = 0; i < 5; i++) do_store(AW'(16'h0080 + i), 32'hAA00 + 32'(i), s[i]);
        for (int i = 0; i < 4; i++)
            chk(s[i] == 0, "R6", "store accepted while not full", 32'(s[i]), 0);
        chk(s[4] > 0, "R6", "fifth store stalls on full queue", 32'(s[4]), 1);
        idle(60);
        chk(log_n - start == 5, "R7", "write count", 32'(log_n - start), 5);
        for (int i = 0; i < 5; i++) begin
            chk(log_addr[start + i] == AW'(16'h0080 + i), "R7", "write order",
                32'(log_addr[start + i]), 32'(16'h0080 + i));
            chk(mem[8'h80 + i] == 32'hAA00 + 32'(i), "R7", "write value",
                mem[8'h80 + i], 32'hAA00 + 32'(i));
        end
    endtask

    task automatic t_refill_order();
        logic [DW-1:0] d; int s;
        do_store(16'h0068, 32'h0000_0068, s);
        do_store(16'h0069, 32'h0000_0069, s);
        do_store(16'h0066, 32'h6666_6666, s);
        do_load(16'h0066, d, s);
        chk(d == 32'h6666_6666, "R8", "refill sees queued store", d, 32'h6666_6666);
        chk(s > 0, "R8", "refill waited", 32'(s), 1);
        idle(30);
    endtask

    task automatic t_conflict();
        logic [DW-1:0] d; int s;
        do_load(16'h0015, d, s);
        do_load(16'h0025, d, s);
        chk(s > 0 && d == init_val(16'h0025), "R9", "same index other tag misses", 32'(s), 1);
        do_load(16'h0015, d, s);
        chk(s > 0, "R9", "evicted line misses again", 32'(s), 1);
        chk(d == init_val(16'h0015), "R9", "data after eviction", d, init_val(16'h0015));
    endtask

    task automatic t_concurrent();
        int s;
        do_store(16'h0090, 32'h9090, s);
        do_store(16'h0091, 32'h9191, s);
        do_store(16'h0092, 32'h9292, s);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0021;
        #1;
        chk(mem_req && mem_we, "R10", "drain write active", {30'h0, mem_req, mem_we}, 32'h3);
        chk(cpu_stall == 1'b0, "R10", "hit during drain not stalled", 32'(cpu_stall), 0);
        chk(cpu_rdata == init_val(16'h0021), "R10", "hit data during drain", cpu_rdata, init_val(16'h0021));
        @(posedge clk); #1;
        cpu_req = 1'b0;
        idle(60);
        chk(mem[8'h92] == 32'h9292, "R7", "last drained value", mem[8'h92], 32'h9292);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_store_hit();
        t_store_miss();
        t_queue();
        t_refill_order();
        t_conflict();
        t_concurrent();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule